// File: doc/BRIEF.md
# Serial RGB LED String Driver

This block feeds a daisy chain of eight addressable RGB LEDs through one serial data line. Every LED takes a 24-bit colour word and then passes later bits along the chain to its neighbour. The block sends the eight words in order, LED 0 first. It then holds the line low for long enough that the chain latches the data and the first LED listens again. After that the frame starts over, with no end.

Each bit takes a fixed window of clock cycles. A bit is coded by how long the line stays high at the start of its window. The colour word is packed as green in bits 23:16, red in bits 15:8 and blue in bits 7:0, and bit 23 goes out first. Three nested counters sequence the frame: a cycle counter inside each bit, a bit counter inside each word, and a slot counter over the words. The slot counter has two extra slots that send nothing, and these two slots make the low latch gap. Each LED's word is read from its input at the moment its slot begins, so an input can change at any time without tearing a word that is being sent.

Top module: `rgb_chain_driver`

## Requirements
- R1: Every bit occupies exactly 125 clock cycles, measured from one rising edge of the line to the next, inside a frame.
- R2: A 1 bit holds the line high for the first 80 cycles of its window and low for the remaining 45.
- R3: A 0 bit holds the line high for the first 40 cycles of its window and low for the remaining 85.
- R4: Each LED receives 24 bits taken from its word in the order bit 23 down to bit 0, so the colour bytes go out green (bits 23:16), then red (15:8), then blue (7:0), each byte most significant bit first.
- R5: The words go out in the order LED 0 to LED 7, where LED k is `colors[24*k+23 : 24*k]`.
- R6: After the last bit of LED 7, the line stays low for two empty slots (6000 cycles) in addition to the low tail of that bit. No pulse appears during this gap.
- R7: An LED's word is sampled when its slot begins. A change to that LED's input while its slot is running has no effect on the bits sent in that frame. A change to a later LED's input does take effect in the same frame.
- R8: The synchronous reset drives the line low from the first clock edge at which it is sampled high. After release, the driver starts with the latch gap, and the first rising edge of the line is seen in the output after the 6001st clock edge following release.
- R9: Frames repeat with no end. The frame after a gap uses the inputs as they stand at each slot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz |
| rst | input | 1 | Synchronous reset, active high |
| colors | input | 192 | Eight packed GRB words, LED k at bits 24*k+23 down to 24*k |
| led_line | output | 1 | Registered serial data line to the LED chain |

## Verification
Two behaviours are hard to reach from the ports. The first is sampling at the slot boundary, which needs an input change that lands inside a particular LED's slot. The bench decodes the line bit by bit and uses the moment it sees the first rising edge of LED 3. At that moment it rewrites the inputs of LED 3 and LED 4, and it expects the old word for LED 3 and the new word for LED 4. The second is a reset in the middle of a word. For this the bench asserts reset partway through LED 1 and then counts the edges to the first pulse, which must come after exactly one full gap.

// File: rtl/rgb_chain_pkg.sv
package rgb_chain_pkg;

  // Line level inside a bit window: high while the cycle index is below the
  // high time chosen by the bit value.
  function automatic logic pulse_level(input logic bit_val,
                                       input int unsigned tick,
                                       input int unsigned one_hi,
                                       input int unsigned zero_hi);
    return tick < (bit_val ? one_hi : zero_hi);
  endfunction

  // Modulo counter step: returns 0 after the last value.
  function automatic int unsigned step_wrap(input int unsigned value,
                                            input int unsigned last);
    return (value == last) ? 0 : value + 1;
  endfunction

endpackage

// File: rtl/rgb_bit_timer.sv
module rgb_bit_timer #(
  parameter int CYC    = 125,
  localparam int TW    = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] tick_o,
  output logic          wrap_o
);
  import rgb_chain_pkg::*;

  logic [TW-1:0] tick_q;

  assign wrap_o = (32'(tick_q) == CYC - 1);
  assign tick_o = tick_q;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= '0;
    else     tick_q <= TW'(step_wrap(32'(tick_q), CYC - 1));
  end
endmodule

// File: rtl/rgb_seq_counters.sv
module rgb_seq_counters #(
  parameter int BITS   = 24,
  parameter int LEDS   = 8,
  parameter int GAPS   = 2,
  localparam int SLOTS = LEDS + GAPS,
  localparam int BW    = $clog2(BITS),
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_wrap_i,
  output logic [BW-1:0] bit_o,
  output logic          bit_wrap_o,
  output logic [SW-1:0] slot_o,
  output logic [SW-1:0] next_slot_o,
  output logic          in_gap_o,
  output logic          load_o
);
  import rgb_chain_pkg::*;

  logic [BW-1:0] bit_q;
  logic [SW-1:0] slot_q;

  assign bit_wrap_o  = (32'(bit_q) == BITS - 1);
  assign load_o      = tick_wrap_i && bit_wrap_o;
  assign next_slot_o = SW'(step_wrap(32'(slot_q), SLOTS - 1));
  assign in_gap_o    = (32'(slot_q) >= LEDS);
  assign bit_o       = bit_q;
  assign slot_o      = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= '0;
      slot_q <= SW'(LEDS);
    end else if (tick_wrap_i) begin
      bit_q <= BW'(step_wrap(32'(bit_q), BITS - 1));
      if (bit_wrap_o) slot_q <= next_slot_o;
    end
  end
endmodule

// File: rtl/rgb_word_shifter.sv
module rgb_word_shifter #(
  parameter int WW     = 24,
  parameter int LEDS   = 8,
  parameter int SW     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEDS*WW-1:0] colors_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [SW-1:0]    next_slot_i,
  output logic             msb_o
);
  logic [WW-1:0] words [LEDS];
  logic [WW-1:0] sel_word;
  logic [WW-1:0] word_q;

  for (genvar k = 0; k < LEDS; k++) begin : g_unpack
    assign words[k] = colors_i[k*WW +: WW];
  end

  // Gap slots match no LED index and therefore load zero.
  always_comb begin
    sel_word = '0;
    for (int k = 0; k < LEDS; k++) begin
      if (next_slot_i == SW'(k)) sel_word = words[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (load_i)  word_q <= sel_word;
    else if (shift_i) word_q <= {word_q[WW-2:0], 1'b0};
  end

  assign msb_o = word_q[WW-1];
endmodule

// File: rtl/rgb_line_encoder.sv
module rgb_line_encoder #(
  parameter int CYC     = 125,
  parameter int ONE_HI  = 80,
  parameter int ZERO_HI = 40,
  localparam int TW     = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tick_i,
  input  logic          bit_i,
  input  logic          gap_i,
  output logic          line_o
);
  import rgb_chain_pkg::*;

  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= !gap_i && pulse_level(bit_i, 32'(tick_i), ONE_HI, ZERO_HI);
  end

  assign line_o = line_q;
endmodule

// File: rtl/rgb_chain_driver.sv
module rgb_chain_driver #(
  parameter int CYC_PER_BIT = 125,
  parameter int ONE_HIGH    = 80,
  parameter int ZERO_HIGH   = 40,
  parameter int COLOR_W     = 8,
  parameter int NUM_LEDS    = 8,
  parameter int GAP_SLOTS   = 2,
  localparam int WORD_W     = 3 * COLOR_W,
  localparam int SLOTS      = NUM_LEDS + GAP_SLOTS,
  localparam int TICK_W     = $clog2(CYC_PER_BIT),
  localparam int BIT_W      = $clog2(WORD_W),
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LEDS*WORD_W-1:0] colors,
  output logic                       led_line
);
  logic [TICK_W-1:0] tick_w;
  logic              tick_wrap_w;
  logic [BIT_W-1:0]  bit_w;
  logic              bit_wrap_w;
  logic [SLOT_W-1:0] slot_w;
  logic [SLOT_W-1:0] next_slot_w;
  logic              in_gap_w;
  logic              load_w;
  logic              msb_w;

  rgb_bit_timer #(.CYC(CYC_PER_BIT)) u_timer (
    .clk(clk), .rst(rst), .tick_o(tick_w), .wrap_o(tick_wrap_w)
  );

  rgb_seq_counters #(.BITS(WORD_W), .LEDS(NUM_LEDS), .GAPS(GAP_SLOTS)) u_seq (
    .clk(clk), .rst(rst), .tick_wrap_i(tick_wrap_w),
    .bit_o(bit_w), .bit_wrap_o(bit_wrap_w), .slot_o(slot_w),
    .next_slot_o(next_slot_w), .in_gap_o(in_gap_w), .load_o(load_w)
  );

  rgb_word_shifter #(.WW(WORD_W), .LEDS(NUM_LEDS), .SW(SLOT_W)) u_shift (
    .clk(clk), .rst(rst), .colors_i(colors), .load_i(load_w),
    .shift_i(tick_wrap_w), .next_slot_i(next_slot_w), .msb_o(msb_w)
  );

  rgb_line_encoder #(.CYC(CYC_PER_BIT), .ONE_HI(ONE_HIGH), .ZERO_HI(ZERO_HIGH)) u_enc (
    .clk(clk), .rst(rst), .tick_i(tick_w), .bit_i(msb_w), .gap_i(in_gap_w),
    .line_o(led_line)
  );
endmodule

// File: rtl/rgb_chain_checker.sv
module rgb_chain_checker #(
  parameter int CYC     = 125,
  parameter int ONE_HI  = 80,
  parameter int ZERO_HI = 40,
  parameter int BITS    = 24,
  parameter int SLOTS   = 10,
  parameter int TW      = 7,
  parameter int BW      = 5,
  parameter int SW      = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          led_line,
  input logic [TW-1:0] tick,
  input logic          tick_wrap,
  input logic [BW-1:0] bit_idx,
  input logic          bit_wrap,
  input logic [SW-1:0] slot,
  input logic          in_gap,
  input logic          msb
);
  assert_tick_range_R1: assert property (@(posedge clk) disable iff (rst)
    32'(tick) < CYC);

  assert_one_high_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_gap && msb && 32'(tick) < ONE_HI) |=> led_line);

  assert_late_low_R2: assert property (@(posedge clk) disable iff (rst)
    (32'(tick) >= ONE_HI) |=> !led_line);

  assert_zero_high_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_gap && !msb && 32'(tick) < ZERO_HI) |=> led_line);

  assert_zero_low_R3: assert property (@(posedge clk) disable iff (rst)
    (!msb && 32'(tick) >= ZERO_HI) |=> !led_line);

  assert_bit_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_wrap && !bit_wrap) |=> (bit_idx == BW'($past(bit_idx) + 1'b1)));

  assert_slot_step_R5: assert property (@(posedge clk) disable iff (rst)
    (tick_wrap && bit_wrap && 32'(slot) != SLOTS - 1) |=> (slot == SW'($past(slot) + 1'b1)));

  assert_gap_low_R6: assert property (@(posedge clk) disable iff (rst)
    in_gap |=> !led_line);

  assert_reset_low_R8: assert property (@(posedge clk)
    rst |=> !led_line);

  assert_slot_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (tick_wrap && bit_wrap && 32'(slot) == SLOTS - 1) |=> (slot == '0));
endmodule

bind rgb_chain_driver rgb_chain_checker #(
  .CYC(CYC_PER_BIT), .ONE_HI(ONE_HIGH), .ZERO_HI(ZERO_HIGH), .BITS(WORD_W),
  .SLOTS(SLOTS), .TW(TICK_W), .BW(BIT_W), .SW(SLOT_W)
) u_chk (
  .clk(clk), .rst(rst), .led_line(led_line), .tick(tick_w),
  .tick_wrap(tick_wrap_w), .bit_idx(bit_w), .bit_wrap(bit_wrap_w),
  .slot(slot_w), .in_gap(in_gap_w), .msb(msb_w)
);

// File: tb/rgb_chain_driver_tb.sv
module rgb_chain_driver_tb;
  localparam int FRAME_BITS = 192;
  localparam int GAP_CYC    = 6000;

  // Stimulus words; each frame must decode back to the words that were applied.
  localparam logic [191:0] VEC [3] = '{
    {24'hAAAA55, 24'h000000, 24'hFFFFFF, 24'h123456,
     24'h800001, 24'h0000FF, 24'h00FF00, 24'hFF0000},
    {24'h0F0F0F, 24'hF0F0F0, 24'h5A5A5A, 24'hC3C3C3,
     24'h010203, 24'hFEDCBA, 24'h7F7F7F, 24'h808080},
    {24'h111111, 24'h222222, 24'h333333, 24'h444444,
     24'h555555, 24'h666666, 24'h777777, 24'h888888}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [191:0] colors;
  logic led_line;
  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  rgb_chain_driver u_dut (.clk(clk), .rst(rst), .colors(colors), .led_line(led_line));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge where the line reads high; returns at the next such point.
  task automatic get_bit(output int h, output int l);
    h = 0;
    l = 0;
    while (led_line) begin h++; @(negedge clk); end
    while (!led_line && l < 20000) begin l++; @(negedge clk); end
  endtask

  task automatic decode_frame(input logic [191:0] exp, input int nbits,
                              input int hook_at, input logic [191:0] hook_val);
    logic [23:0] got = '0;
    for (int i = 0; i < nbits; i++) begin
      int h, l;
      int led = i / 24;
      int pos = 23 - (i % 24);
      logic expb = exp[led*24 + pos];
      get_bit(h, l);
      got[pos] = (h > 60);
      if (expb) check(h == 80, "R2 high time", h, 80);
      else      check(h == 40, "R3 high time", h, 40);
      if (i == FRAME_BITS - 1)
        check(l == 125 - h + GAP_CYC, "R6 gap length", l, 125 - h + GAP_CYC);
      else
        check(h + l == 125, "R1 bit period", h + l, 125);
      if ((i % 24) == 23)
        check(got == exp[led*24 +: 24], "R4 R5 R7 R9 word", int'(got), int'(exp[led*24 +: 24]));
      if (i + 1 == hook_at) colors = hook_val;
    end
  endtask

  task automatic count_to_first_pulse(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!led_line && n < 20000);
  endtask

  initial begin
    wait (cyc >= 180000);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 180000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [191:0] mix;
    logic [191:0] exp3;
    int n;
    colors = VEC[0];
    repeat (3) @(negedge clk);
    check(led_line == 1'b0, "R8 low in reset", int'(led_line), 0);
    rst = 1'b0;
    count_to_first_pulse(n);
    check(n == GAP_CYC + 1, "R8 first pulse after gap", n, GAP_CYC + 1);

    // Table walk: next vector applied during LED 7, taken up by the next frame (R9).
    for (int v = 0; v < 2; v++)
      decode_frame(VEC[v], FRAME_BITS, FRAME_BITS - 1, VEC[v+1]);

    // R7: at the first pulse of LED 3 rewrite LED 3 and LED 4.
    mix = VEC[2];
    mix[3*24 +: 24] = 24'hA50F3C;
    mix[4*24 +: 24] = 24'h817EC3;
    exp3 = VEC[2];
    exp3[4*24 +: 24] = mix[4*24 +: 24];
    decode_frame(exp3, FRAME_BITS, 72, mix);

    // R9: next frame uses the new words from its start; reset hits inside LED 1.
    decode_frame(mix, 30, 0, mix);
    rst = 1'b1;
    @(negedge clk);
    check(led_line == 1'b0, "R8 low on mid-frame reset", int'(led_line), 0);
    rst = 1'b0;
    count_to_first_pulse(n);
    check(n == GAP_CYC + 1, "R8 restart after gap", n, GAP_CYC + 1);
    decode_frame(mix, 24, 0, mix);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule